// File: doc/BRIEF.md
# Timer Prescaler Reset and Synchronization Controller

This block drives the divider chains that feed three timer/counters. Timers 0 and 1 share one prescaler clocked by the system clock. Timer 2 has its own prescaler in a second clock domain. That domain may be an independent clock, or it may be the system clock itself. Software uses one control register to request a single-cycle reset of either prescaler. It can also enter a hold mode, in which both reset requests stay asserted. While held, every timer is frozen and can be loaded with a start value. When the hold is cleared, all timers resume from the same clock edge with their divider phases aligned.

When timer 2 runs from its own clock, its reset request crosses into that domain through a two-flop synchronizer. The reset is applied there and an acknowledge returns through a second two-flop synchronizer. The request bit reads as set until that acknowledge arrives, so software can poll it to learn when the reset has taken effect. The three small counters inside the block exist to make prescaler and hold behaviour visible at the ports. Each counter picks its count enable through a 3-bit select input.

Top module: `tmr_presync_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 and all counters read 0. In the 8-bit register, bit 7 is the hold-mode bit, bit 1 the timer-2 prescaler reset request and bit 0 the shared prescaler reset request. Bits 6..2 always read 0.
- R2: Outside hold mode, a write that sets bit 0 makes it read 1 for exactly one cycle, and hardware then clears it.
- R3: A shared-prescaler reset halts timers 0 and 1 together for one count cycle. Timer 2 keeps counting.
- R4: When timer 2 is in same-clock mode (t2_async_mode=0), a write that sets bit 1 clears it after one cycle. It halts timer 2 for one count cycle and leaves timer 0 unaffected.
- R5: When timer 2 is in separate-clock mode, bit 1 stays 1 until the acknowledge returns from the other domain. That takes at least 4 system cycles; after it, the bit clears.
- R6: In separate-clock mode, outside hold mode, writing 0 to bit 1 does not cancel a pending timer-2 prescaler reset.
- R7: While bit 7 is 1, hardware keeps bits 0 and 1 at their written values. A timer whose prescaler reset is held does not increment, even with the undivided select; it still accepts a load.
- R8: A write that changes bit 7 from 1 to 0 clears bits 0 and 1 in the same cycle. All held timers then take their first step on the same edge.
- R9: Select encoding is 1 = every cycle, 2 = every 8th, 3 = every 64th, 4 = every 256th and 5 = every 1024th cycle. Values 0, 6 and 7 stop the counter. After a prescaler reset is released, a divide-by-N timer first increments N edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, system domain |
| aclk | input | 1 | Timer-2 clock (same as clk in same-clock mode) |
| arst_n | input | 1 | Asynchronous active-low reset, timer-2 domain |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| t2_async_mode | input | 1 | 1: timer 2 runs from an independent aclk |
| sel0 | input | 3 | Timer 0 count select |
| sel1 | input | 3 | Timer 1 count select |
| sel2 | input | 3 | Timer 2 count select |
| ld_en | input | 3 | Per-timer load strobe (bit k loads timer k; timer 2 in aclk domain) |
| ld_val | input | 8 | Load value |
| t0_count | output | 8 | Timer 0 count |
| t1_count | output | 8 | Timer 1 count |
| t2_count | output | 8 | Timer 2 count |

## Verification
The lockstep scenario is run for every select value 0 to 7 with the three timers loaded to different start values while held. The bench then follows each count every cycle after release, against floor(n/N) for divide-by-N or a flat value for the stop codes. This separates a misplaced tap, a wrong select decode, a divider left unreset, and a timer that leaks counts while held. One-shot resets are applied to each prescaler alone while all timers count every cycle, which shows which timers a given bit halts. In separate-clock mode the bench times how long bit 1 stays set, and adds an overwrite with 0, to tell an acknowledged clear from an immediate one.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;
  localparam int NTAPS = 4;
  localparam int PRE_W = 10;

  typedef enum logic [2:0] {
    SEL_OFF     = 3'd0,
    SEL_DIV1    = 3'd1,
    SEL_DIV8    = 3'd2,
    SEL_DIV64   = 3'd3,
    SEL_DIV256  = 3'd4,
    SEL_DIV1024 = 3'd5
  } cnt_sel_e;

  // number of low counter bits that must be all ones for tap idx
  function automatic int tap_bits(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tps_sync2.sv
`timescale 1ns/1ps
module tps_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/tps_prescaler.sv
`timescale 1ns/1ps
module tps_prescaler
  import tps_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [NTAPS-1:0] tap
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (clr) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    localparam int B = tap_bits(g);
    assign tap[g] = !clr && (&cnt_q[B-1:0]);
  end

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  for (genvar g = 1; g < NTAPS; g++) begin : g_nest
    // R9
    tap_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap[g] |-> tap[g-1]);
  end
endmodule

// File: rtl/tps_timer.sv
`timescale 1ns/1ps
module tps_timer
  import tps_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [NTAPS-1:0] tap,
  input  logic [2:0]       sel,
  input  logic             load,
  input  logic [W-1:0]     load_val,
  output logic [W-1:0]     count
);
  logic         step;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    case (cnt_sel_e'(sel))
      SEL_DIV1:    step = 1'b1;
      SEL_DIV8:    step = tap[0];
      SEL_DIV64:   step = tap[1];
      SEL_DIV256:  step = tap[2];
      SEL_DIV1024: step = tap[3];
      default:     step = 1'b0;
    endcase
    step = step && !hold;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R7
  held_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !load |=> $stable(cnt_q));
endmodule

// File: rtl/tps_ctrl_reg.sv
`timescale 1ns/1ps
module tps_ctrl_reg #(
  parameter int DW      = 8,
  parameter int HOLD_B  = 7,
  parameter int ARST_B  = 1,
  parameter int SRST_B  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          t2_async,
  input  logic          t2_ack,
  output logic [DW-1:0] rd_data,
  output logic          sync_rst,
  output logic          t2_rst_req
);
  logic hold_q, hold_d;
  logic srst_q, srst_d;
  logic arst_q, arst_d;

  always_comb begin
    hold_d = hold_q;
    srst_d = srst_q;
    arst_d = arst_q;
    if (wr_en) begin
      hold_d = wr_data[HOLD_B];
      if (wr_data[HOLD_B]) begin
        srst_d = wr_data[SRST_B];
        arst_d = wr_data[ARST_B];
      end else if (hold_q) begin
        srst_d = 1'b0;
        arst_d = 1'b0;
      end else begin
        srst_d = wr_data[SRST_B];
        arst_d = wr_data[ARST_B] | (arst_q & t2_async);
      end
    end else if (!hold_q) begin
      srst_d = 1'b0;
      arst_d = t2_async ? (arst_q & ~t2_ack) : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      srst_q <= 1'b0;
      arst_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      srst_q <= srst_d;
      arst_q <= arst_d;
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[HOLD_B] = hold_q;
    rd_data[ARST_B] = arst_q;
    rd_data[SRST_B] = srst_q;
  end

  assign sync_rst   = srst_q;
  assign t2_rst_req = arst_q;

  // R2
  srst_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q && !hold_q && !wr_en |=> !srst_q);

  // R5
  arst_wait_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t2_async && arst_q && !t2_ack && !hold_q && !wr_en |=> arst_q);

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && !wr_en |=> hold_q && $stable({arst_q, srst_q}));

  // R8
  release_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> !srst_q && !arst_q);
endmodule

// File: rtl/tmr_presync_ctrl.sv
`timescale 1ns/1ps
module tmr_presync_ctrl
  import tps_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aclk,
  input  logic             arst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic             t2_async_mode,
  input  logic [2:0]       sel0,
  input  logic [2:0]       sel1,
  input  logic [2:0]       sel2,
  input  logic [2:0]       ld_en,
  input  logic [TMR_W-1:0] ld_val,
  output logic [TMR_W-1:0] t0_count,
  output logic [TMR_W-1:0] t1_count,
  output logic [TMR_W-1:0] t2_count
);
  logic             sync_rst, t2_req, t2_req_a, t2_ack_s, t2_clr;
  logic [NTAPS-1:0] tap_s, tap_a;

  tps_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .t2_async(t2_async_mode), .t2_ack(t2_ack_s), .rd_data(rd_data),
    .sync_rst(sync_rst), .t2_rst_req(t2_req)
  );

  // system domain: shared prescaler for timers 0 and 1
  tps_prescaler #(.W(PRE_W)) u_pre_sync (
    .clk(clk), .rst_n(rst_n), .clr(sync_rst), .tap(tap_s)
  );

  tps_timer #(.W(TMR_W)) u_tmr0 (
    .clk(clk), .rst_n(rst_n), .hold(sync_rst), .tap(tap_s), .sel(sel0),
    .load(ld_en[0]), .load_val(ld_val), .count(t0_count)
  );

  tps_timer #(.W(TMR_W)) u_tmr1 (
    .clk(clk), .rst_n(rst_n), .hold(sync_rst), .tap(tap_s), .sel(sel1),
    .load(ld_en[1]), .load_val(ld_val), .count(t1_count)
  );

  // request into the timer-2 domain and acknowledge back
  tps_sync2 u_req_sync (.clk(aclk), .rst_n(arst_n), .d(t2_req),   .q(t2_req_a));
  tps_sync2 u_ack_sync (.clk(clk),  .rst_n(rst_n),  .d(t2_req_a), .q(t2_ack_s));

  // same-clock mode uses the register bit directly (aclk is clk then)
  assign t2_clr = t2_async_mode ? t2_req_a : t2_req;

  tps_prescaler #(.W(PRE_W)) u_pre_t2 (
    .clk(aclk), .rst_n(arst_n), .clr(t2_clr), .tap(tap_a)
  );

  tps_timer #(.W(TMR_W)) u_tmr2 (
    .clk(aclk), .rst_n(arst_n), .hold(t2_clr), .tap(tap_a), .sel(sel2),
    .load(ld_en[2]), .load_val(ld_val), .count(t2_count)
  );

  // R3
  shared_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst && (sel0 == sel1) && !ld_en[0] && !ld_en[1] &&
    (t0_count == t1_count) |=> (t0_count == t1_count));
endmodule

// File: tb/tmr_presync_ctrl_tb.sv
`timescale 1ns/1ps
module tmr_presync_ctrl_tb;
  logic       clk = 1'b0, slow_clk = 1'b0, aclk;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       t2_async_mode = 1'b0;
  logic [2:0] sel0 = '0, sel1 = '0, sel2 = '0;
  logic [2:0] ld_en = '0;
  logic [7:0] ld_val = '0;
  logic [7:0] t0_count, t1_count, t2_count;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;
  always #7 slow_clk = ~slow_clk;
  assign aclk = t2_async_mode ? slow_clk : clk;

  tmr_presync_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .aclk(aclk), .arst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .t2_async_mode(t2_async_mode), .sel0(sel0), .sel1(sel1), .sel2(sel2),
    .ld_en(ld_en), .ld_val(ld_val),
    .t0_count(t0_count), .t1_count(t1_count), .t2_count(t2_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int idx, input logic [7:0] v);
    ld_en = 3'b001 << idx; ld_val = v;
    @(negedge clk);
    ld_en = '0;
  endtask

  task automatic sweep(input logic [2:0] s);
    int div;
    int last;
    case (s)
      3'd1: div = 1; 3'd2: div = 8; 3'd3: div = 64;
      3'd4: div = 256; 3'd5: div = 1024; default: div = 0;
    endcase
    last = (2 * div + 3 > 20) ? 2 * div + 3 : 20;
    sel0 = s; sel1 = s; sel2 = s;
    wr(8'h83);
    load(0, 8'd10); load(1, 8'd50); load(2, 8'd200);
    for (int i = 0; i < 4; i++) @(negedge clk);
    // R7: held timers keep loaded values, any select
    check(t0_count == 8'd10,  "R7", t0_count, 10);
    check(t1_count == 8'd50,  "R7", t1_count, 50);
    check(t2_count == 8'd200, "R7", t2_count, 200);
    check(rd_data == 8'h83, "R7", rd_data, 8'h83);
    wr(8'h00);
    // R8: both request bits cleared with the release
    check(rd_data == 8'h00, "R8", rd_data, 0);
    for (int n = 0; n <= last; n++) begin
      int inc;
      inc = (div == 0) ? 0 : n / div;
      // R8 R9: lockstep from release edge at the selected rate
      check(t0_count == 8'(10 + inc),  "R8/R9 t0", t0_count, 10 + inc);
      check(t1_count == 8'(50 + inc),  "R8/R9 t1", t1_count, 50 + inc);
      check(t2_count == 8'(200 + inc), "R8/R9 t2", t2_count, 200 + inc);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a0, a1, a2;
    int waited;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rd_data == 8'h00, "R1", rd_data, 0);
    check(t0_count == 0 && t1_count == 0 && t2_count == 0, "R1", t0_count, 0);

    // R1: unused bits read zero
    wr(8'hFF);
    check(rd_data == 8'h83, "R1", rd_data, 8'h83);
    wr(8'h00);
    check(rd_data == 8'h00, "R1", rd_data, 0);

    sel0 = 3'd1; sel1 = 3'd1; sel2 = 3'd1;
    repeat (3) @(negedge clk);

    // R2 R3: shared prescaler reset
    a0 = t0_count; a1 = t1_count; a2 = t2_count;
    wr(8'h01);
    check(rd_data == 8'h01, "R2", rd_data, 1);
    @(negedge clk);
    check(rd_data == 8'h00, "R2", rd_data, 0);
    repeat (8) @(negedge clk);
    check(8'(t0_count - a0) == 8'd9,  "R3 t0", 8'(t0_count - a0), 9);
    check(8'(t1_count - a1) == 8'd9,  "R3 t1", 8'(t1_count - a1), 9);
    check(8'(t2_count - a2) == 8'd10, "R3 t2", 8'(t2_count - a2), 10);

    // R4: timer-2 reset, same-clock mode
    a0 = t0_count; a2 = t2_count;
    wr(8'h02);
    check(rd_data == 8'h02, "R4", rd_data, 2);
    @(negedge clk);
    check(rd_data == 8'h00, "R4", rd_data, 0);
    repeat (8) @(negedge clk);
    check(8'(t2_count - a2) == 8'd9,  "R4 t2", 8'(t2_count - a2), 9);
    check(8'(t0_count - a0) == 8'd10, "R4 t0", 8'(t0_count - a0), 10);

    // R5: separate-clock mode waits for acknowledge
    t2_async_mode = 1'b1;
    repeat (10) @(negedge clk);
    wr(8'h02);
    waited = 1;
    repeat (3) @(negedge clk);
    waited += 3;
    check(rd_data[1] == 1'b1, "R5", rd_data[1], 1);
    while (rd_data[1] && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    check(rd_data[1] == 1'b0, "R5", rd_data[1], 0);
    check(waited >= 4 && waited < 100, "R5 latency", waited, 4);

    // R6: writing 0 does not cancel a pending request
    repeat (20) @(negedge clk);
    wr(8'h02);
    wr(8'h00);
    check(rd_data[1] == 1'b1, "R6", rd_data[1], 1);
    waited = 0;
    while (rd_data[1] && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    check(rd_data[1] == 1'b0, "R6", rd_data[1], 0);
    repeat (20) @(negedge clk);
    t2_async_mode = 1'b0;
    repeat (5) @(negedge clk);

    // R7 R8 R9: lockstep sweep over every select value
    for (int s = 0; s < 8; s++) sweep(3'(s));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule